// File: doc/BRIEF.md
# Shared-Weight Seven-Lane Dot-Product Cluster

This block is one compute cluster of a convolution engine. It holds seven dot-product units. Each unit keeps a row of eight signed 8-bit pixels and, when enabled, multiplies them lane by lane against one row of eight signed 8-bit weights. It sums the eight products through a pipelined three-level adder tree. The weights are not stored per unit. A single 256-byte weight bank feeds all seven units, and one row-select input picks which 8-byte weight row every enabled unit uses in a given cycle.

Pixels are plain signed integers with a sign bit and seven integer bits. Weights are signed fractions with a sign bit and seven fraction bits, so they lie in [-1, +1). Each product therefore carries seven fraction bits. Each unit shifts its sum right by seven (arithmetic, rounding toward minus infinity) and clamps it to a 16-bit signed partial sum. That partial sum appears with a valid strobe three cycles after the issue.

Typical use is as follows. Load the weight bank one byte per cycle. Load a pixel row into each unit that is mapped. Then sweep the row select across the stored weight rows with the mapped units enabled. When the sweep is done, load fresh pixels and sweep the same weights again. Units that are not mapped are left disabled and stay silent.

Top module: `pe_cluster`

## Requirements
- R1: A write with `wgt_we` high stores `wgt_data` into the weight bank. Address bits [7:3] select the weight row (0..31) and bits [2:0] select the lane (0..7) within that row.
- R2: `pix_load[p]` captures eight pixels into unit p. Lane l of unit p comes from `pix_row[(p*8+l)*8 +: 8]`. An issue in the same cycle as a load uses the pixels held before that load, and a load never disturbs operations already in flight.
- R3: For an issue of unit p with weight row r, the result is sum over l of pixel[l]*weight[r][l], arithmetically shifted right by 7 (floor), placed in `psum[p*16 +: 16]` as a signed 16-bit value. The result covers the extremes -1016 and +1024.
- R4: `psum_vld[p]` is high for exactly one cycle, three cycles after each cycle in which `pe_en[p]` was high. Issues on consecutive cycles produce results on consecutive cycles.
- R5: A unit whose `pe_en` is low produces no valid strobe, and its `psum` output keeps the last value it delivered.
- R6: If a weight write and an issue address the same weight row in the same cycle, the issue uses the bank contents from before the write. The following issue sees the new byte.
- R7: All units use the single shared `row_sel` weight row, and each combines that row with its own pixels independently of the others.
- R8: During and after reset, every `psum_vld` is low and every `psum` is zero. The weight bank and all pixel rows read as zero until they are written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wgt_we | input | 1 | Weight bank write strobe |
| wgt_addr | input | 8 | Weight byte address: row in [7:3], lane in [2:0] |
| wgt_data | input | 8 | Weight byte, sign + 7 fraction bits |
| row_sel | input | 5 | Weight row read by all enabled units |
| pix_load | input | 7 | Per-unit pixel row load strobe |
| pix_row | input | 448 | Pixel rows, 64 bits per unit, lane l of unit p at bit (p*8+l)*8 |
| pe_en | input | 7 | Per-unit issue enable |
| psum | output | 112 | Partial sums, 16 bits per unit at bit p*16 |
| psum_vld | output | 7 | Per-unit result strobe |

## Verification
The sweeps pair all-minus-128 pixels with all-minus-128 weights, giving +1024. They also pair -128 with +127, giving -1016, and use hashed patterns that make many negative sums with nonzero low bits. A design that truncated toward zero, lost a sign extension or used a too-narrow tree would be off on exactly those vectors. Every weight row is swept against several pixel sets in back-to-back issue cycles, and the three-cycle latency and one-strobe-per-issue rule are checked at every cycle. An alternating-enable round catches units that fire or change `psum` while disabled. Same-cycle load-and-issue and write-and-issue cases would show a design that let new pixels or new weights leak into the issuing cycle.

// File: rtl/pe_cluster_pkg.sv
package pe_cluster_pkg;
    // Default geometry of one cluster
    localparam int DEF_NUM_PE     = 7;
    localparam int DEF_TREE_DEPTH = 3;    // 2**depth lanes per unit
    localparam int DEF_PIX_W      = 8;    // sign + 7 integer bits
    localparam int DEF_WGT_W      = 8;    // sign + 7 fraction bits
    localparam int DEF_FRAC_BITS  = 7;    // fraction bits dropped from the sum
    localparam int DEF_PSUM_W     = 16;
    localparam int DEF_BANK_BYTES = 256;

    // Bit-width needed to address n items (at least 1)
    function automatic int idx_w(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction
endpackage

// File: rtl/pe_wgt_bank.sv
module pe_wgt_bank #(
    parameter int ROWS  = 32,
    parameter int LANES = 8,
    parameter int WGT_W = 8,
    localparam int RW   = pe_cluster_pkg::idx_w(ROWS),
    localparam int LW   = pe_cluster_pkg::idx_w(LANES),
    localparam int AW   = RW + LW
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we,
    input  logic [AW-1:0]          waddr,
    input  logic [WGT_W-1:0]       wdata,
    input  logic [RW-1:0]          rsel,
    output logic [LANES*WGT_W-1:0] rrow
);
    logic [WGT_W-1:0] mem [ROWS][LANES];

    // Flop bank: the read below sees pre-edge contents, so a same-cycle
    // write is invisible to the issuing operation.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int r = 0; r < ROWS; r++) begin
                for (int l = 0; l < LANES; l++) begin
                    mem[r][l] <= '0;
                end
            end
        end else if (we) begin
            mem[waddr[AW-1:LW]][waddr[LW-1:0]] <= wdata;
        end
    end

    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            rrow[l*WGT_W +: WGT_W] = mem[rsel][l];
        end
    end
endmodule

// File: rtl/pe_mac_lane.sv
module pe_mac_lane #(
    parameter int TREE_DEPTH = 3,
    parameter int PIX_W      = 8,
    parameter int WGT_W      = 8,
    parameter int FRAC_BITS  = 7,
    parameter int PSUM_W     = 16,
    localparam int LANES     = 1 << TREE_DEPTH
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load,
    input  logic [LANES*PIX_W-1:0]   pix_in,
    input  logic                     en,
    input  logic [LANES*WGT_W-1:0]   wrow,
    output logic signed [PSUM_W-1:0] psum,
    output logic                     vld
);
    localparam int PROD_W = PIX_W + WGT_W;
    localparam int S1_W   = PROD_W + 1;
    localparam int S2_W   = PROD_W + 2;
    localparam int S3_W   = PROD_W + 3;
    localparam logic signed [S3_W-1:0] MAXV = S3_W'((64'sd1 <<< (PSUM_W-1)) - 64'sd1);
    localparam logic signed [S3_W-1:0] MINV = -MAXV - S3_W'(1);

    logic signed [PIX_W-1:0]  pix_q [LANES];
    logic signed [WGT_W-1:0]  wgt   [LANES];
    logic signed [PROD_W-1:0] prod  [LANES];
    logic signed [S1_W-1:0]   s1_q  [LANES/2];
    logic signed [S2_W-1:0]   s2_q  [LANES/4];
    logic signed [S3_W-1:0]   s3, s3_sh;
    logic signed [PSUM_W-1:0] clamped;
    logic                     v1_q, v2_q;

    // Pixel row register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int l = 0; l < LANES; l++) pix_q[l] <= '0;
        end else if (load) begin
            for (int l = 0; l < LANES; l++) pix_q[l] <= pix_in[l*PIX_W +: PIX_W];
        end
    end

    // Lane multipliers (signed integer x signed fraction)
    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            wgt[l]  = wrow[l*WGT_W +: WGT_W];
            prod[l] = PROD_W'(pix_q[l]) * PROD_W'(wgt[l]);
        end
    end

    // Tree level 1: pairs of products
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < LANES/2; i++) s1_q[i] <= '0;
            v1_q <= 1'b0;
        end else begin
            v1_q <= en;
            if (en) begin
                for (int i = 0; i < LANES/2; i++)
                    s1_q[i] <= S1_W'(prod[2*i]) + S1_W'(prod[2*i+1]);
            end
        end
    end

    // Tree level 2
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < LANES/4; i++) s2_q[i] <= '0;
            v2_q <= 1'b0;
        end else begin
            v2_q <= v1_q;
            if (v1_q) begin
                for (int i = 0; i < LANES/4; i++)
                    s2_q[i] <= S2_W'(s1_q[2*i]) + S2_W'(s1_q[2*i+1]);
            end
        end
    end

    // Tree level 3, rescale and clamp
    always_comb begin
        s3 = '0;
        for (int i = 0; i < LANES/4; i++) s3 = s3 + S3_W'(s2_q[i]);
        s3_sh = s3 >>> FRAC_BITS;
        if (s3_sh > MAXV)      clamped = MAXV[PSUM_W-1:0];
        else if (s3_sh < MINV) clamped = MINV[PSUM_W-1:0];
        else                   clamped = s3_sh[PSUM_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            psum <= '0;
            vld  <= 1'b0;
        end else begin
            vld <= v2_q;
            if (v2_q) psum <= clamped;
        end
    end
endmodule

// File: rtl/pe_cluster.sv
module pe_cluster #(
    parameter int NUM_PE     = pe_cluster_pkg::DEF_NUM_PE,
    parameter int TREE_DEPTH = pe_cluster_pkg::DEF_TREE_DEPTH,
    parameter int PIX_W      = pe_cluster_pkg::DEF_PIX_W,
    parameter int WGT_W      = pe_cluster_pkg::DEF_WGT_W,
    parameter int FRAC_BITS  = pe_cluster_pkg::DEF_FRAC_BITS,
    parameter int PSUM_W     = pe_cluster_pkg::DEF_PSUM_W,
    parameter int BANK_BYTES = pe_cluster_pkg::DEF_BANK_BYTES,
    localparam int LANES     = 1 << TREE_DEPTH,
    localparam int ROWS      = BANK_BYTES / LANES,
    localparam int RW        = pe_cluster_pkg::idx_w(ROWS),
    localparam int AW        = RW + pe_cluster_pkg::idx_w(LANES)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wgt_we,
    input  logic [AW-1:0]                   wgt_addr,
    input  logic [WGT_W-1:0]                wgt_data,
    input  logic [RW-1:0]                   row_sel,
    input  logic [NUM_PE-1:0]               pix_load,
    input  logic [NUM_PE*LANES*PIX_W-1:0]   pix_row,
    input  logic [NUM_PE-1:0]               pe_en,
    output logic [NUM_PE*PSUM_W-1:0]        psum,
    output logic [NUM_PE-1:0]               psum_vld
);
    localparam int ROW_BITS = LANES * PIX_W;

    logic [LANES*WGT_W-1:0] shared_row;

    pe_wgt_bank #(
        .ROWS  (ROWS),
        .LANES (LANES),
        .WGT_W (WGT_W)
    ) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wgt_we),
        .waddr (wgt_addr),
        .wdata (wgt_data),
        .rsel  (row_sel),
        .rrow  (shared_row)
    );

    for (genvar p = 0; p < NUM_PE; p++) begin : g_unit
        logic signed [PSUM_W-1:0] unit_psum;

        pe_mac_lane #(
            .TREE_DEPTH (TREE_DEPTH),
            .PIX_W      (PIX_W),
            .WGT_W      (WGT_W),
            .FRAC_BITS  (FRAC_BITS),
            .PSUM_W     (PSUM_W)
        ) u_mac (
            .clk    (clk),
            .rst_n  (rst_n),
            .load   (pix_load[p]),
            .pix_in (pix_row[p*ROW_BITS +: ROW_BITS]),
            .en     (pe_en[p]),
            .wrow   (shared_row),
            .psum   (unit_psum),
            .vld    (psum_vld[p])
        );

        assign psum[p*PSUM_W +: PSUM_W] = unit_psum;
    end
endmodule

// File: rtl/pe_cluster_chk.sv
module pe_cluster_chk #(
    parameter int NUM_PE = 7,
    parameter int PSUM_W = 16,
    parameter int BOUND  = 1024
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [NUM_PE-1:0]        pe_en,
    input logic [NUM_PE*PSUM_W-1:0] psum,
    input logic [NUM_PE-1:0]        psum_vld
);
    logic [1:0] since_rst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    // R8: no strobe can appear before a full pipeline has passed since reset
    p_quiet_after_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst != 2'd3) |-> (psum_vld == '0));

    // R4: every strobe is exactly three cycles after an issue, and vice versa
    p_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3) |-> (psum_vld == $past(pe_en, 3)));

    for (genvar p = 0; p < NUM_PE; p++) begin : g_chk
        // R5: without a strobe the delivered value stays put
        p_hold_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
            ((since_rst != 2'd0) && !psum_vld[p]) |-> $stable(psum[p*PSUM_W +: PSUM_W]));

        // R3: a rescaled eight-lane sum cannot leave the reachable range
        p_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
            psum_vld[p] |-> (($signed(psum[p*PSUM_W +: PSUM_W]) <= BOUND) &&
                             ($signed(psum[p*PSUM_W +: PSUM_W]) >= -BOUND)));
    end
endmodule

bind pe_cluster pe_cluster_chk #(
    .NUM_PE (NUM_PE),
    .PSUM_W (PSUM_W),
    .BOUND  (LANES << (PIX_W + WGT_W - 2 - FRAC_BITS))
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pe_en    (pe_en),
    .psum     (psum),
    .psum_vld (psum_vld)
);

// File: tb/tb_pe_cluster.sv
`timescale 1ns/1ps
module tb_pe_cluster;
    localparam int NP = 7;
    localparam int NL = 8;
    localparam int NR = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wgt_we = 1'b0;
    logic [7:0]        wgt_addr = '0;
    logic [7:0]        wgt_data = '0;
    logic [4:0]        row_sel = '0;
    logic [NP-1:0]     pix_load = '0;
    logic [NP*64-1:0]  pix_row = '0;
    logic [NP-1:0]     pe_en = '0;
    logic [NP*16-1:0]  psum;
    logic [NP-1:0]     psum_vld;

    pe_cluster dut (
        .clk(clk), .rst_n(rst_n), .wgt_we(wgt_we), .wgt_addr(wgt_addr),
        .wgt_data(wgt_data), .row_sel(row_sel), .pix_load(pix_load),
        .pix_row(pix_row), .pe_en(pe_en), .psum(psum), .psum_vld(psum_vld)
    );

    always #2.5 clk = ~clk;

    int    n_chk = 0;
    int    n_bad = 0;
    bit    done = 0;
    string cur_req = "R8";

    // bench model
    int mrf  [NR][NL];
    int mpix [NP][NL];
    bit v1 [NP], v2 [NP], v3 [NP];
    int d1 [NP], d2 [NP], d3 [NP];
    int hold [NP];

    function automatic int wgen(int r, int l);
        if (r == 0) return -128;
        if (r == 1) return 127;
        if (r == 2) return -1;
        return ((r*37 + l*11 + 5) % 256) - 128;
    endfunction

    function automatic int pgen(int k, int p, int l);
        if (k == 0) return -128;
        if (k == 1) return 127;
        return ((k*53 + p*29 + l*17 + 3) % 256) - 128;
    endfunction

    task automatic check_one(int p);
        int act;
        act = int'($signed(psum[p*16 +: 16]));
        n_chk++;
        if (psum_vld[p] !== v3[p] || act != hold[p]) begin
            n_bad++;
            $display("FAIL %s unit %0d: vld=%0b psum=%0d expected vld=%0b psum=%0d",
                     cur_req, p, psum_vld[p], act, v3[p], hold[p]);
        end
    endtask

    task automatic step();
        bit nv [NP];
        int nd [NP];
        for (int p = 0; p < NP; p++) begin
            int acc = 0;
            for (int l = 0; l < NL; l++) acc += mpix[p][l] * mrf[row_sel][l];
            nv[p] = pe_en[p];
            nd[p] = acc >>> 7;
        end
        if (wgt_we) mrf[wgt_addr >> 3][wgt_addr & 8'h7] = int'($signed(wgt_data));
        for (int p = 0; p < NP; p++)
            if (pix_load[p])
                for (int l = 0; l < NL; l++)
                    mpix[p][l] = int'($signed(pix_row[(p*NL+l)*8 +: 8]));
        @(posedge clk);
        #1;
        for (int p = 0; p < NP; p++) begin
            v3[p] = v2[p]; d3[p] = d2[p];
            v2[p] = v1[p]; d2[p] = d1[p];
            v1[p] = nv[p]; d1[p] = nd[p];
            if (v3[p]) hold[p] = d3[p];
            check_one(p);
        end
    endtask

    task automatic idle(int n);
        wgt_we = 0; pix_load = '0; pe_en = '0;
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic set_pix(int p, int k);
        for (int l = 0; l < NL; l++) pix_row[(p*NL+l)*8 +: 8] = 8'(pgen(k, p, l));
    endtask

    initial begin : watchdog
        #(200000 * 5);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : stim
        for (int r = 0; r < NR; r++) for (int l = 0; l < NL; l++) mrf[r][l] = 0;
        for (int p = 0; p < NP; p++) begin
            for (int l = 0; l < NL; l++) mpix[p][l] = 0;
            v1[p] = 0; v2[p] = 0; v3[p] = 0; d1[p] = 0; d2[p] = 0; d3[p] = 0; hold[p] = 0;
        end
        repeat (3) @(posedge clk);
        #1;
        // R8: reset state at the ports
        for (int p = 0; p < NP; p++) check_one(p);
        rst_n = 1'b1;
        // R8: empty bank and empty pixels give zero sums
        pe_en = '1; row_sel = 5'd9; step();
        idle(4);

        // R1: fill the bank byte by byte, units idle
        cur_req = "R1";
        for (int a = 0; a < 256; a++) begin
            wgt_we = 1; wgt_addr = 8'(a); wgt_data = 8'(wgen(a >> 3, a & 7));
            step();
        end
        idle(3);

        // Sweeps: R4 round 0, R3 rounds 1/4/5, R7 round 2, R5 round 3
        for (int k = 0; k < 6; k++) begin
            case (k)
                0: cur_req = "R4";
                2: cur_req = "R7";
                3: cur_req = "R5";
                default: cur_req = "R3";
            endcase
            for (int p = 0; p < NP; p++) set_pix(p, k);
            pix_load = '1; step();
            pix_load = '0;
            for (int r = 0; r < NR; r++) begin
                pe_en   = (k == 3) ? 7'h55 : '1;
                row_sel = 5'(r);
                step();
            end
            idle(4);
        end

        // R2: load and issue in one cycle (old pixels), load mid-flight
        cur_req = "R2";
        set_pix(0, 6); set_pix(1, 7);
        pix_load = 7'h03; pe_en = 7'h03; row_sel = 5'd5; step();
        set_pix(0, 8);
        pix_load = 7'h01; pe_en = 7'h03; row_sel = 5'd6; step();
        pix_load = '0;    pe_en = 7'h03; row_sel = 5'd6; step();
        idle(4);

        // R6: write and issue same row, same cycle; then issue again
        cur_req = "R6";
        wgt_we = 1; wgt_addr = {5'd4, 3'd2}; wgt_data = 8'h81;
        pe_en = '1; row_sel = 5'd4; step();
        wgt_we = 0; step();
        idle(4);

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule